// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects a bank of maskable peripheral interrupt lines and a small group of nonmaskable trap lines and funnels them into a single interrupt request toward a CPU. Alongside the request it presents the winning vector number, the priority level attached to it, and the 24-bit program-memory address of the vector slot that the CPU should fetch next. Each maskable source owns an enable bit and a 3-bit level that software programs through a simple indexed write port. A source is eligible only when it is enabled, pending, and its level is strictly above the current CPU priority.

Traps always beat maskable sources. Among maskable sources, the higher programmed level wins. When levels tie, the lower vector number wins. Trap `t` uses vector `t`, and maskable source `i` uses vector `8 + i`. A control bit selects the alternate vector table, which has the same layout as the primary one. The vector address is the table base plus twice the vector number: the primary base is 0x000004 and the alternate base is 0x000100.

A small state machine sequences each request through three states:
- `ST_IDLE` (no request) moves to `ST_REQ` when an eligible winner exists.
- `ST_REQ` (request shown) re-evaluates the winner every cycle. It moves to `ST_RETIRE` on acknowledge, or back to `ST_IDLE` if no winner is left.
- `ST_RETIRE` always returns to `ST_IDLE`.

The CPU acknowledges with a one-cycle pulse. The block then clears that source's pending flag and takes its level as the new CPU priority. The CPU restores its priority on return through a direct write port.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the request output is low, the CPU priority reads 0 and the primary table is selected.
- R2: Among eligible maskable sources, the one with the highest programmed level is presented, whatever its index.
- R3: Among eligible maskable sources of equal level, the one with the lowest vector number (vector = 8 + source index) is presented.
- R4: A maskable source that is disabled, or whose level is not strictly greater than the CPU priority, never raises a request. Only trap vectors 0..4 and source vectors 8..60 ever appear.
- R5: A pending trap outranks every maskable source and ignores the enable bits and the CPU priority. Trap t presents vector t at level 8, and the lower trap index wins.
- R6: The presented address is 0x000004 + 2*vector when the alternate-select bit is 0, and 0x000100 + 2*vector when it is 1. It follows that bit at any time.
- R7: A line sampled high at a clock edge raises the request at the next clock edge. This latency is the same for every source and trap.
- R8: An acknowledge while the request is high drops the request for the next cycle, clears that vector's pending flag, and loads the presented level into the CPU priority.
- R9: While a request is outstanding, a newly pending source of higher rank replaces the presented vector one cycle after it becomes pending.
- R10: A CPU priority write (not coincident with an acknowledge) sets the CPU priority. This can release sources that were previously blocked.
- R11: A one-cycle pulse on a line leaves its pending flag set until that vector is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 53 | Maskable interrupt lines, source i maps to vector 8+i |
| trap_irq | input | 5 | Nonmaskable trap lines, trap t maps to vector t |
| cfg_we | input | 1 | Write strobe for one source's enable and level |
| cfg_idx | input | 6 | Source index for the configuration write |
| cfg_en | input | 1 | Enable value to write |
| cfg_lvl | input | 3 | Priority level value to write |
| alt_we | input | 1 | Write strobe for the table-select bit |
| alt_val | input | 1 | Table-select value, 1 selects the alternate table |
| cpl_we | input | 1 | Write strobe for the CPU priority (return path) |
| cpl_val | input | 4 | CPU priority value to write |
| ack | input | 1 | One-cycle acknowledge from the CPU |
| irq | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 7 | Presented vector number |
| irq_lvl | output | 4 | Level of the presented vector (8 for traps) |
| irq_addr | output | 24 | Program address of the presented vector slot |
| cpu_lvl | output | 4 | Current CPU priority |

## Verification
The bench fires pairs of sources in the same cycle at equal and at different levels. A controller that ranked by index alone, or that broke ties toward the higher index, would present the wrong vector. A trap is injected while a maskable request is already showing. A design that held its first choice would keep the maskable vector, and one that ranked traps below level 7 would never switch. The table-select bit is flipped between two interrupts and again before a later one, which exposes a wrong alternate base or a selection that is latched too early. Further cases cover a source that is blocked by the CPU priority and then released by a priority write, and two traps arriving together. These catch a missing priority compare, an acknowledge that clears the wrong pending flag, and a drifted latency.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int TRAP_SLOTS  = 8;
    localparam int TABLE_SLOTS = 126;
    localparam int VEC_W       = 7;
    localparam int LVL_W       = 3;
    localparam int CPL_W       = 4;
    localparam int ADDR_W      = 24;
    localparam logic [CPL_W-1:0]  TRAP_CPL = 4'd8;
    localparam logic [ADDR_W-1:0] PRI_BASE = 24'h000004;
    localparam logic [ADDR_W-1:0] ALT_BASE = PRI_BASE + ADDR_W'(2 * TABLE_SLOTS);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REQ    = 2'd1,
        ST_RETIRE = 2'd2
    } vic_state_t;
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank
    import vic_pkg::*;
#(
    parameter int N_SRC  = 53,
    parameter int N_TRAP = 5,
    parameter int IDX_W  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_SRC-1:0]              src_irq,
    input  logic [N_TRAP-1:0]             trap_irq,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic                          cfg_en,
    input  logic [LVL_W-1:0]              cfg_lvl,
    input  logic [N_SRC-1:0]              clr_src,
    input  logic [N_TRAP-1:0]             clr_trap,
    output logic [N_SRC-1:0]              en,
    output logic [N_SRC-1:0][LVL_W-1:0]   lvl,
    output logic [N_SRC-1:0]              pend,
    output logic [N_TRAP-1:0]             tpend
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en[i]   <= 1'b0;
                lvl[i]  <= '0;
                pend[i] <= 1'b0;
            end else begin
                if (cfg_we && cfg_idx == IDX_W'(i)) begin
                    en[i]  <= cfg_en;
                    lvl[i] <= cfg_lvl;
                end
                pend[i] <= (pend[i] & ~clr_src[i]) | src_irq[i];
            end
        end
    end

    for (genvar t = 0; t < N_TRAP; t++) begin : g_trap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tpend[t] <= 1'b0;
            else        tpend[t] <= (tpend[t] & ~clr_trap[t]) | trap_irq[t];
        end
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int N_SRC  = 53,
    parameter int N_TRAP = 5
) (
    input  logic [N_SRC-1:0]              en,
    input  logic [N_SRC-1:0][LVL_W-1:0]   lvl,
    input  logic [N_SRC-1:0]              pend,
    input  logic [N_TRAP-1:0]             tpend,
    input  logic [CPL_W-1:0]              cpu_lvl,
    output logic                          win_valid,
    output logic [VEC_W-1:0]              win_vec,
    output logic [CPL_W-1:0]              win_lvl
);
    logic             t_found, m_found;
    logic [VEC_W-1:0] t_idx, m_idx;
    logic [LVL_W-1:0] m_lvl;

    always_comb begin
        t_found = 1'b0;
        t_idx   = '0;
        for (int t = N_TRAP - 1; t >= 0; t--) begin
            if (tpend[t]) begin
                t_found = 1'b1;
                t_idx   = VEC_W'(t);
            end
        end
        m_found = 1'b0;
        m_lvl   = '0;
        m_idx   = '0;
        // descending scan with >= leaves the lowest index on a tie
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (en[i] && pend[i] && ({1'b0, lvl[i]} > cpu_lvl)
                && (!m_found || lvl[i] >= m_lvl)) begin
                m_found = 1'b1;
                m_lvl   = lvl[i];
                m_idx   = VEC_W'(i + TRAP_SLOTS);
            end
        end
        win_valid = t_found | m_found;
        win_vec   = t_found ? t_idx : m_idx;
        win_lvl   = t_found ? TRAP_CPL : {1'b0, m_lvl};
    end
endmodule

// File: rtl/vic_vec_addr.sv
module vic_vec_addr
    import vic_pkg::*;
(
    input  logic              alt_sel,
    input  logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] base;

    always_comb begin
        base = alt_sel ? ALT_BASE : PRI_BASE;
        addr = base + ADDR_W'({vec, 1'b0});
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int N_SRC  = 53,
    parameter int N_TRAP = 5,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     src_irq,
    input  logic [N_TRAP-1:0]    trap_irq,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic                 cfg_en,
    input  logic [LVL_W-1:0]     cfg_lvl,
    input  logic                 alt_we,
    input  logic                 alt_val,
    input  logic                 cpl_we,
    input  logic [CPL_W-1:0]     cpl_val,
    input  logic                 ack,
    output logic                 irq,
    output logic [VEC_W-1:0]     irq_vec,
    output logic [CPL_W-1:0]     irq_lvl,
    output logic [ADDR_W-1:0]    irq_addr,
    output logic [CPL_W-1:0]     cpu_lvl
);
    vic_state_t state, state_nx;

    logic [N_SRC-1:0]            en, pend, clr_src;
    logic [N_SRC-1:0][LVL_W-1:0] lvl;
    logic [N_TRAP-1:0]           tpend, clr_trap;
    logic                        win_valid;
    logic [VEC_W-1:0]            win_vec, vec_q;
    logic [CPL_W-1:0]            win_lvl, lvl_q, cpu_q;
    logic                        alt_q;
    logic                        take;

    assign take = (state == ST_REQ) && ack;

    vic_src_bank #(.N_SRC(N_SRC), .N_TRAP(N_TRAP), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .trap_irq(trap_irq),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_lvl(cfg_lvl),
        .clr_src(clr_src), .clr_trap(clr_trap),
        .en(en), .lvl(lvl), .pend(pend), .tpend(tpend)
    );

    vic_arbiter #(.N_SRC(N_SRC), .N_TRAP(N_TRAP)) u_arb (
        .en(en), .lvl(lvl), .pend(pend), .tpend(tpend), .cpu_lvl(cpu_q),
        .win_valid(win_valid), .win_vec(win_vec), .win_lvl(win_lvl)
    );

    vic_vec_addr u_addr (.alt_sel(alt_q), .vec(vec_q), .addr(irq_addr));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   state_nx = win_valid ? ST_REQ : ST_IDLE;
            ST_REQ:    state_nx = ack ? ST_RETIRE : (win_valid ? ST_REQ : ST_IDLE);
            ST_RETIRE: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // pending clear for the presented vector on acknowledge
    always_comb begin
        clr_src  = '0;
        clr_trap = '0;
        if (take) begin
            for (int t = 0; t < N_TRAP; t++)
                if (vec_q == VEC_W'(t)) clr_trap[t] = 1'b1;
            for (int i = 0; i < N_SRC; i++)
                if (vec_q == VEC_W'(i + TRAP_SLOTS)) clr_src[i] = 1'b1;
        end
    end

    // output / data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            lvl_q <= '0;
            cpu_q <= '0;
            alt_q <= 1'b0;
        end else begin
            if (take)        cpu_q <= lvl_q;
            else if (cpl_we) cpu_q <= cpl_val;
            if (alt_we)      alt_q <= alt_val;
            if (state != ST_RETIRE && !take && win_valid) begin
                vec_q <= win_vec;
                lvl_q <= win_lvl;
            end
        end
    end

    assign irq     = (state == ST_REQ);
    assign irq_vec = vec_q;
    assign irq_lvl = lvl_q;
    assign cpu_lvl = cpu_q;
endmodule

module vic_chk
    import vic_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              irq,
    input logic [VEC_W-1:0]  irq_vec,
    input logic [CPL_W-1:0]  irq_lvl,
    input logic [ADDR_W-1:0] irq_addr,
    input logic [CPL_W-1:0]  cpu_lvl
);
    a_r8_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack) |=> !irq);

    a_r8_cpu_takes_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack) |=> (cpu_lvl == $past(irq_lvl)));

    a_r5_trap_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_vec < VEC_W'(TRAP_SLOTS)) |-> (irq_lvl == TRAP_CPL));

    a_r4_only_implemented: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_vec < 7'd5 || (irq_vec >= 7'd8 && irq_vec < 7'd61)));

    a_r4_above_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_vec >= VEC_W'(TRAP_SLOTS) && $stable(cpu_lvl)) |-> (irq_lvl > cpu_lvl));

    a_r6_addr_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_addr == PRI_BASE + ADDR_W'({irq_vec, 1'b0})
              || irq_addr == ALT_BASE + ADDR_W'({irq_vec, 1'b0})));
endmodule

bind vec_irq_ctrl vic_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ack(ack), .irq(irq), .irq_vec(irq_vec),
    .irq_lvl(irq_lvl), .irq_addr(irq_addr), .cpu_lvl(cpu_lvl)
);

// File: tb/vec_irq_ctrl_tb.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;
    localparam int NS = 53;
    localparam int NT = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_irq = '0;
    logic [NT-1:0] trap_irq = '0;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_idx = '0;
    logic          cfg_en = 1'b0;
    logic [2:0]    cfg_lvl = '0;
    logic          alt_we = 1'b0, alt_val = 1'b0;
    logic          cpl_we = 1'b0;
    logic [3:0]    cpl_val = '0;
    logic          ack = 1'b0;
    logic          irq;
    logic [6:0]    irq_vec;
    logic [3:0]    irq_lvl, cpu_lvl;
    logic [23:0]   irq_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vec_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .trap_irq(trap_irq),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_lvl(cfg_lvl),
        .alt_we(alt_we), .alt_val(alt_val), .cpl_we(cpl_we), .cpl_val(cpl_val),
        .ack(ack), .irq(irq), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
        .irq_addr(irq_addr), .cpu_lvl(cpu_lvl)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_en[NS];
    int m_lvl[NS];
    bit m_pend[NS];
    bit m_tp[NT];
    int m_cpu, m_alt, m_state, m_vec, m_wl;

    function automatic void pick(output bit ok, output int v, output int l);
        ok = 0; v = 0; l = 0;
        for (int t = 0; t < NT; t++)
            if (!ok && m_tp[t]) begin ok = 1; v = t; l = 8; end
        if (ok) return;
        for (int i = 0; i < NS; i++)
            if (m_en[i] && m_pend[i] && m_lvl[i] > m_cpu && (!ok || m_lvl[i] > l)) begin
                ok = 1; v = 8 + i; l = m_lvl[i];
            end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_en[i]) begin m_en[i] = 0; m_lvl[i] = 0; m_pend[i] = 0; end
            foreach (m_tp[t]) m_tp[t] = 0;
            m_cpu = 0; m_alt = 0; m_state = 0; m_vec = 0; m_wl = 0;
        end else begin
            bit ok; int v, l; int clr_v;
            pick(ok, v, l);
            clr_v = -1;
            if (m_state == 1 && ack) begin
                clr_v = m_vec; m_cpu = m_wl; m_state = 2;
            end else begin
                if (cpl_we) m_cpu = int'(cpl_val);
                if (m_state == 2) m_state = 0;
                else if (ok) begin m_state = 1; m_vec = v; m_wl = l; end
                else m_state = 0;
            end
            if (alt_we) m_alt = int'(alt_val);
            if (cfg_we) begin m_en[cfg_idx] = cfg_en; m_lvl[cfg_idx] = int'(cfg_lvl); end
            for (int i = 0; i < NS; i++)
                m_pend[i] = (m_pend[i] && clr_v != 8 + i) || src_irq[i];
            for (int t = 0; t < NT; t++)
                m_tp[t] = (m_tp[t] && clr_v != t) || trap_irq[t];
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 model irq", int'(irq), int'(m_state == 1));
            chk("R8 model cpu_lvl", int'(cpu_lvl), m_cpu);
            if (m_state == 1) begin
                chk("R2 model vec", int'(irq_vec), m_vec);
                chk("R5 model lvl", int'(irq_lvl), m_wl);
                chk("R6 model addr", int'(irq_addr), (m_alt != 0 ? 256 : 4) + 2 * m_vec);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic cfg(int idx, bit e, int l);
        cfg_we = 1; cfg_idx = 6'(idx); cfg_en = e; cfg_lvl = 3'(l);
        tick();
        cfg_we = 0;
    endtask

    task automatic pulse(logic [NS-1:0] s, logic [NT-1:0] t);
        src_irq = s; trap_irq = t;
        tick();
        src_irq = '0; trap_irq = '0;
    endtask

    task automatic do_ack();
        ack = 1; tick(); ack = 0;
    endtask

    task automatic set_cpl(int v);
        cpl_we = 1; cpl_val = 4'(v); tick(); cpl_we = 0;
    endtask

    task automatic set_alt(bit v);
        alt_we = 1; alt_val = v; tick(); alt_we = 0;
    endtask

    function automatic logic [NS-1:0] sb(int i);
        return (NS)'(1) << i;
    endfunction

    initial begin : watchdog
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        tick();
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 cpu_lvl after reset", int'(cpu_lvl), 0);

        // unequal levels in the same cycle
        cfg(3, 1, 2); cfg(10, 1, 5);
        pulse(sb(3) | sb(10), '0);
        tick();
        chk("R2 higher level wins vec", int'(irq_vec), 18);
        chk("R7 irq one edge after capture", int'(irq), 1);
        chk("R6 primary addr", int'(irq_addr), 24'h000028);
        do_ack();
        chk("R8 irq dropped", int'(irq), 0);
        chk("R8 cpu takes level", int'(cpu_lvl), 5);
        tick(); tick();
        chk("R4 blocked by cpu level", int'(irq), 0);
        set_cpl(0);
        tick();
        chk("R10 released by cpl write", int'(irq_vec), 11);
        chk("R11 sticky pending lvl", int'(irq_lvl), 2);
        do_ack(); set_cpl(0);

        // equal levels, then trap during maskable request
        cfg(20, 1, 4); cfg(7, 1, 4);
        pulse(sb(20) | sb(7), '0);
        tick();
        chk("R3 tie lower vector", int'(irq_vec), 15);
        pulse('0, 5'b00100);
        tick();
        chk("R9 trap replaces vec", int'(irq_vec), 2);
        chk("R5 trap level", int'(irq_lvl), 8);
        chk("R6 trap addr", int'(irq_addr), 24'h000008);
        do_ack();
        tick(); tick();
        chk("R4 level 4 under cpu 8", int'(irq), 0);

        // alternate table between two interrupts
        set_alt(1);
        set_cpl(0);
        tick();
        chk("R6 alternate addr v15", int'(irq_addr), 24'h00011E);
        do_ack(); set_cpl(0);
        tick();
        chk("R6 alternate addr v28", int'(irq_addr), 24'h000138);
        do_ack(); set_cpl(0); set_alt(0);

        // disabled source, later enabled
        cfg(30, 0, 7);
        pulse(sb(30), '0);
        tick(); tick();
        chk("R4 disabled source silent", int'(irq), 0);
        cfg(30, 1, 7);
        tick();
        chk("R6 primary again v38", int'(irq_addr), 24'h000050);
        do_ack(); set_cpl(0);

        // two traps together under high cpu level
        set_cpl(7);
        pulse('0, 5'b10001);
        tick();
        chk("R5 trap 0 first", int'(irq_vec), 0);
        chk("R6 trap 0 addr", int'(irq_addr), 24'h000004);
        do_ack();
        tick(); tick();
        chk("R5 trap 4 next", int'(irq_vec), 4);
        chk("R6 trap 4 addr", int'(irq_addr), 24'h00000C);
        do_ack(); set_cpl(0);
        tick(); tick();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule